// File: doc/BRIEF.md
# Console Byte Packetizer with CR-before-LF Expansion

This block sits between a character console source and a bulk OUT sender. Characters arrive one per handshake on a valid/ready stream, with a marker on the final character of each message. The block gathers them into chunks of up to eight bytes. When a chunk is complete, it presents the chunk and its byte count on a packet interface and holds it there until the sender acknowledges it.

Every line feed in the stream becomes a carriage return followed by the same line feed. The return is placed in the current chunk. If that return takes the last free slot, the line feed opens the next chunk. A chunk is released as soon as it is full, or when the byte that ends the message has been placed. A chunk that holds no bytes is never released. While a chunk waits for acknowledgement, the input is stalled. The USB transaction itself is performed outside this block.

Top module: `crlf_packetizer`

## Requirements
- R1: After reset, `in_ready` is 1 and `pkt_valid` is 0.
- R2: A chunk holds at most MAX_BYTES (8) bytes. It is presented with `pkt_len` = 8 as soon as its eighth byte has been placed, whether or not the message has ended.
- R3: Each input byte 0x0A (line feed) produces two output bytes: 0x0D (carriage return) and then the same 0x0A. Exactly one 0x0D is inserted per line feed.
- R4: If the inserted 0x0D occupies the last slot of a chunk, that chunk is released with 0x0D as its final byte. The 0x0A then appears as byte 0 of the next chunk. No byte is lost or duplicated.
- R5: When the input byte flagged by `in_last` has been placed (including the 0x0A that it expands into), the partial chunk is released. `pkt_len` is between 1 and 8 and no zero-length chunk is ever presented.
- R6: Byte k of a chunk, in arrival order, sits on `pkt_data[8k+7:8k]`. Byte lanes at or above `pkt_len` read as zero.
- R7: While `pkt_valid` is 1, `in_ready` is 0 and `pkt_data`/`pkt_len` stay stable until the cycle that `pkt_ack` is sampled high.
- R8: `pkt_ack` asserted while no chunk is presented has no effect. No chunk appears and no later chunk is altered.
- R9: Input bytes other than 0x0A, including a bare 0x0D, pass through unchanged and alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input character present |
| in_data | input | 8 | Input character |
| in_last | input | 1 | Character ends the message |
| in_ready | output | 1 | Block accepts the character this cycle |
| pkt_valid | output | 1 | Chunk presented |
| pkt_data | output | 64 | Chunk bytes, byte 0 in bits 7:0 |
| pkt_len | output | 4 | Number of valid bytes in the chunk |
| pkt_ack | input | 1 | Sender has taken the chunk |

## Verification
Two events can fall in the same cycle. The first case is a line feed whose owed 0x0A is still pending when the chunk fills. The second case is an end-of-message byte landing in the eighth slot, so the full-chunk release and the end-of-message flush coincide. The sweep runs every message length from 1 to 17 against several line-feed placements. These include a leading letter followed by line feeds and a line feed at index 7, which put the carriage return in slot 7 and make messages end exactly on a chunk boundary. A model in the bench expands and splits each message arithmetically. Each released chunk's length and lanes are compared against that model, and a chunk beginning with 0x0A after one ending in 0x0D is judged as the straddle case.

// File: rtl/crlf_chunk_pkg.sv
package crlf_chunk_pkg;
    localparam int          BYTE_W  = 8;
    localparam logic [7:0]  CHAR_LF = 8'h0A;
    localparam logic [7:0]  CHAR_CR = 8'h0D;
endpackage

// File: rtl/crlf_expand.sv
module crlf_expand
    import crlf_chunk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              s_valid,
    output logic [BYTE_W-1:0] s_data,
    output logic              s_last,
    input  logic              s_ready
);
    typedef struct packed {
        logic owe_lf;
        logic owe_last;
    } exp_st_t;

    exp_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        in_ready = 1'b0;
        s_valid  = 1'b0;
        s_data   = in_data;
        s_last   = in_last;
        if (st_q.owe_lf) begin
            s_valid = 1'b1;
            s_data  = CHAR_LF;
            s_last  = st_q.owe_last;
            if (s_ready) begin
                st_d.owe_lf   = 1'b0;
                st_d.owe_last = 1'b0;
            end
        end else begin
            s_valid  = in_valid;
            in_ready = s_ready;
            if (in_data == CHAR_LF) begin
                s_data = CHAR_CR;
                s_last = 1'b0;
                if (in_valid && s_ready) begin
                    st_d.owe_lf   = 1'b1;
                    st_d.owe_last = in_last;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: an accepted line feed stalls input and owes exactly one LF next
    a_r3_lf_owed: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_data == CHAR_LF) |=>
            (!in_ready && s_valid && s_data == CHAR_LF));

    // R9: other bytes pass straight through
    a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_data != CHAR_LF) |-> (s_data == in_data));
endmodule

// File: rtl/chunk_fill.sv
module chunk_fill
    import crlf_chunk_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    localparam int DATA_W   = MAX_BYTES * BYTE_W,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              pkt_valid,
    output logic [DATA_W-1:0] pkt_data,
    output logic [LEN_W-1:0]  pkt_len,
    input  logic              pkt_ack
);
    localparam logic [LEN_W-1:0] FULL_CNT = LEN_W'(MAX_BYTES);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [LEN_W-1:0]  cnt;
        logic              full;
    } fill_st_t;

    fill_st_t st_d, st_q;
    logic              take;
    logic [DATA_W-1:0] lane_next;

    assign take = s_valid && !st_q.full;

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
        assign lane_next[g*BYTE_W +: BYTE_W] =
            (take && st_q.cnt == LEN_W'(g)) ? s_data : st_q.data[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        st_d    = st_q;
        s_ready = !st_q.full;
        if (st_q.full) begin
            if (pkt_ack) begin
                st_d.full = 1'b0;
                st_d.cnt  = '0;
                st_d.data = '0;
            end
        end else if (take) begin
            st_d.data = lane_next;
            st_d.cnt  = st_q.cnt + LEN_W'(1);
            if ((st_q.cnt + LEN_W'(1)) == FULL_CNT || s_last)
                st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pkt_valid = st_q.full;
    assign pkt_data  = st_q.data;
    assign pkt_len   = st_q.cnt;

    // R2 R5: presented length is never zero and never above the limit
    a_r5_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len != '0 && pkt_len <= FULL_CNT));

    // R2: the slot that fills the chunk releases it
    a_r2_full_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && st_q.cnt == FULL_CNT - LEN_W'(1)) |=>
            (pkt_valid && pkt_len == FULL_CNT));

    // R5: the end-of-message byte releases the chunk
    a_r5_last_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_last) |=> pkt_valid);

    // R7: a presented chunk is held until acknowledged
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ack) |=> (pkt_valid && $stable(pkt_data) && $stable(pkt_len)));

    // R8: acknowledge while idle creates nothing
    a_r8_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_valid && !s_valid) |=> !pkt_valid);
endmodule

// File: rtl/crlf_packetizer.sv
module crlf_packetizer
    import crlf_chunk_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    localparam int DATA_W   = MAX_BYTES * BYTE_W,
    localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              pkt_valid,
    output logic [DATA_W-1:0] pkt_data,
    output logic [LEN_W-1:0]  pkt_len,
    input  logic              pkt_ack
);
    logic              s_valid;
    logic [BYTE_W-1:0] s_data;
    logic              s_last;
    logic              s_ready;

    crlf_expand u_expand (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_ready (in_ready),
        .s_valid  (s_valid),
        .s_data   (s_data),
        .s_last   (s_last),
        .s_ready  (s_ready)
    );

    chunk_fill #(.MAX_BYTES(MAX_BYTES)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .s_last    (s_last),
        .s_ready   (s_ready),
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data),
        .pkt_len   (pkt_len),
        .pkt_ack   (pkt_ack)
    );

    // R7: input stalls while a chunk waits for acknowledgement
    a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !in_ready);
endmodule

// File: tb/crlf_packetizer_tb.sv
module crlf_packetizer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        pkt_valid;
    logic [63:0] pkt_data;
    logic [3:0]  pkt_len;
    logic        pkt_ack = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_go   = 1'b0;
    bit all_sent = 1'b0;

    logic [63:0] exp_data_q[$];
    int          exp_len_q[$];
    logic [63:0] cur = '0;
    int          cur_n = 0;

    always #5 clk = ~clk;

    crlf_packetizer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .pkt_valid(pkt_valid),
        .pkt_data(pkt_data), .pkt_len(pkt_len), .pkt_ack(pkt_ack)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic flush_model();
        exp_data_q.push_back(cur);
        exp_len_q.push_back(cur_n);
        cur   = '0;
        cur_n = 0;
    endtask

    task automatic put_model(input logic [7:0] b);
        cur[cur_n*8 +: 8] = b;
        cur_n++;
        if (cur_n == 8) flush_model();
    endtask

    task automatic model(input logic [7:0] b, input bit last);
        if (b == 8'h0A) begin
            put_model(8'h0D);
            put_model(8'h0A);
        end else begin
            put_model(b);
        end
        if (last && cur_n > 0) flush_model();
    endtask

    function automatic logic [7:0] gen_byte(input int len, input int p, input int i);
        logic [7:0] letter;
        letter = 8'h41 + 8'((i * 5 + len) % 26);
        case (p)
            0: return letter;
            1: return 8'h0A;
            2: return (i == len - 1) ? 8'h0A : letter;
            3: return (i % 3 == 2) ? 8'h0A : letter;
            4: return (i == 7 || i == 14) ? 8'h0A : letter;
            5: return (i % 2 == 1) ? 8'h0D : 8'h0A;
            default: return (i == 0) ? letter : 8'h0A;
        endcase
    endfunction

    task automatic send_byte(input logic [7:0] b, input bit last);
        model(b, last);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = last;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    // monitor and acknowledger
    initial begin
        logic [7:0] prev_tail;
        int npk;
        prev_tail = 8'h00;
        npk = 0;
        wait (rst_n);
        @(posedge clk); #1;
        // R8: acknowledge pulses while idle
        pkt_ack = 1'b1;
        repeat (3) @(posedge clk);
        #1 pkt_ack = 1'b0;
        @(negedge clk);
        check(!pkt_valid, "R8 idle ack made no chunk", 64'(pkt_valid), 64'd0);
        check(in_ready, "R8 idle ack left input ready", 64'(in_ready), 64'd1);
        mon_go = 1'b1;
        forever begin
            @(negedge clk);
            if (pkt_valid) begin
                logic [63:0] ed;
                int el;
                logic [63:0] held;
                if (exp_len_q.size() == 0) begin
                    check(1'b0, "R5 unexpected chunk", 64'(pkt_len), 64'd0);
                    ed = '0; el = 0;
                end else begin
                    ed = exp_data_q.pop_front();
                    el = exp_len_q.pop_front();
                    check(pkt_len == 4'(el), "R2 R5 chunk length", 64'(pkt_len), 64'(el));
                    check(pkt_data == ed, "R3 R6 R9 chunk bytes", pkt_data, ed);
                    if (prev_tail == 8'h0D && ed[7:0] == 8'h0A)
                        check(pkt_data[7:0] == 8'h0A, "R4 straddled LF leads chunk",
                              64'(pkt_data[7:0]), 64'h0A);
                    prev_tail = ed[(el > 0 ? el - 1 : 0)*8 +: 8];
                end
                check(!in_ready, "R7 input stalled while chunk pending", 64'(in_ready), 64'd0);
                held = pkt_data;
                repeat (npk % 3) @(negedge clk);
                if (npk % 3 != 0)
                    check(pkt_valid && pkt_data == held, "R7 chunk held until ack",
                          pkt_data, held);
                npk++;
                @(posedge clk); #1 pkt_ack = 1'b1;
                @(posedge clk);
                @(posedge clk); #1 pkt_ack = 1'b0;  // second cycle is a stray ack (R8)
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // stimulus
    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
        check(pkt_valid == 1'b0, "R1 pkt_valid after reset", 64'(pkt_valid), 64'd0);
        rst_n = 1'b1;
        wait (mon_go);
        @(posedge clk); #1;
        for (int p = 0; p < 7; p++) begin
            for (int len = 1; len <= 17; len++) begin
                for (int i = 0; i < len; i++) begin
                    send_byte(gen_byte(len, p, i), i == len - 1);
                    if (i % 4 == 3) begin
                        @(posedge clk); #1;
                    end
                end
            end
        end
        all_sent = 1'b1;
        repeat (40) @(posedge clk);
        @(negedge clk);
        check(exp_len_q.size() == 0, "R5 every chunk released",
              64'(exp_len_q.size()), 64'd0);
        check(!pkt_valid && in_ready, "R5 no empty trailing chunk",
              64'(pkt_valid), 64'd0);
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule